// File: doc/BRIEF.md
# FIFO-to-RAM Drain Sequencer

This block sits in the destination clock domain of a crossing built around a dual-clock FIFO. Whenever the FIFO reports data, it pops one word and stores it into a 256-entry RAM. Words go to consecutive addresses starting at zero. The block raises the RAM read enable in the same cycle as the write, so the stored word appears on the RAM output one edge later. It also keeps a running count of the words it has moved.

The FIFO's 2-bit ECC status comes through unchanged. Corrected and uncorrectable events are recorded in two sticky flags. The FIFO core, the RAM array and the ECC decoder are outside this block.

The address register idles at all-ones because the address is incremented before each write. The word counter is one bit wider than the address, so a complete fill reads as 256. A transfer that stalls on an empty FIFO resumes at the next free address.

Top module: `fram_drain_seq`

## Requirements
- R1: Asynchronous active-low reset puts the block in its idle state: the address output is all-ones (0xFF), the word count is 0, both sticky flags are 0, and the read request and both RAM enables are low.
- R2: While idle with the FIFO empty flag high, the read request and the RAM enables stay low and the address does not change.
- R3: In the first cycle after empty is seen low while idle, the read request is high, the RAM write enable is low, and the address has moved up by one, wrapping from 0xFF to 0x00.
- R4: The cycle that follows a read request always has the RAM write enable and read enable both high and the read request low. The RAM data output carries the FIFO read data, written at the address set in the request cycle.
- R5: Each write cycle raises the word count by exactly one. After 256 words the count reads 256 and the final word sits at address 0xFF.
- R6: While empty stays low, request cycles and write cycles alternate, and the two are never high together. When empty is high at the end of a write cycle, the block returns to idle after writing that word.
- R7: Returning to idle keeps the address and the word count, so the next word after a stall lands at the following address.
- R8: The ECC status output always equals the FIFO ECC status input (00 no error, 10 corrected single-bit error, 11 uncorrectable).
- R9: The uncorrectable flag is set when status 11 is present during a write cycle. Status 11 outside write cycles has no effect.
- R10: The corrected flag is set when status 10 is present during a write cycle. Status 00 or 01 sets neither flag.
- R11: Once set, a sticky flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Destination-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_empty_i | input | 1 | FIFO empty flag, read side |
| fifo_data_i | input | DATA_W | FIFO read data |
| fifo_ecc_i | input | 2 | FIFO ECC status |
| fifo_rdreq_o | output | 1 | FIFO read request |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_data_o | output | DATA_W | RAM write data |
| ram_wren_o | output | 1 | RAM write enable |
| ram_rden_o | output | 1 | RAM read enable |
| word_count_o | output | ADDR_W+1 | Words written so far |
| ecc_status_o | output | 2 | ECC status, passed through |
| ecc_corr_o | output | 1 | Sticky corrected-error flag |
| ecc_uncorr_o | output | 1 | Sticky uncorrectable-error flag |

## Verification
The drain path is tested with three FIFO patterns.

- **Isolated single words.** These show the exact request, write and idle cycle sequence and the zero-address landing.
- **A second isolated word after an idle gap.** This separates correct resume from an address or count that reset on idle.
- **A long back-to-back burst.** This holds empty low for hundreds of cycles. It exposes broken alternation, address wrap, the final 0xFF landing and a count that stops short of 256.

ECC status codes 01, 10 and 11 are each sent with a written word. Code 11 is also forced while the block is idle. This tells flag decoding apart from write-gating.

// File: rtl/fram_pkg.sv
package fram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_INCADR = 2'd1,
    ST_WRITE  = 2'd2
  } fram_state_e;

  localparam logic [1:0] ECC_FIXED = 2'b10;
  localparam logic [1:0] ECC_FATAL = 2'b11;
endpackage

// File: rtl/fram_seq_fsm.sv
module fram_seq_fsm
  import fram_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_i,
  output logic rdreq_o,
  output logic wr_o,
  output logic step_o
);
  fram_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:   if (!empty_i) state_n = ST_INCADR;
      ST_INCADR: state_n = ST_WRITE;
      ST_WRITE:  state_n = empty_i ? ST_IDLE : ST_INCADR;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_n;
  end

  assign rdreq_o = (state_q == ST_INCADR);
  assign wr_o    = (state_q == ST_WRITE);
  // address moves on entry to INCADR so it is valid during the request
  assign step_o  = (state_n == ST_INCADR);

  assert_req_then_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdreq_o |=> (wr_o && !rdreq_o));
  assert_req_write_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !rdreq_o);
  assert_idle_on_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdreq_o && !wr_o && empty_i) |=> (!rdreq_o && !wr_o));
endmodule

// File: rtl/fram_addr_ctr.sv
module fram_addr_ctr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W:0]   count_o
);
  localparam int unsigned CNT_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '1;
      count_q <= '0;
    end else begin
      if (step_i) addr_q  <= addr_q + ADDR_ONE;
      if (wr_i)   count_q <= count_q + CNT_ONE;
    end
  end

  assign addr_o  = addr_q;
  assign count_o = count_q;

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (addr_q == ADDR_W'($past(addr_q) + ADDR_ONE)));
  assert_addr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(addr_q));
  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (count_q == CNT_W'($past(count_q) + CNT_ONE)));
  assert_count_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(count_q));
endmodule

// File: rtl/fram_ecc_flags.sv
module fram_ecc_flags
  import fram_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] ecc_i,
  output logic       corr_o,
  output logic       uncorr_o
);
  logic corr_q, uncorr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_q   <= 1'b0;
      uncorr_q <= 1'b0;
    end else if (wr_i) begin
      if (ecc_i == ECC_FIXED) corr_q   <= 1'b1;
      if (ecc_i == ECC_FATAL) uncorr_q <= 1'b1;
    end
  end

  assign corr_o   = corr_q;
  assign uncorr_o = uncorr_q;

  assert_corr_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_q |=> corr_q);
  assert_uncorr_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_q |=> uncorr_q);
  assert_uncorr_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ecc_i == ECC_FATAL) |=> uncorr_q);
  assert_corr_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ecc_i == ECC_FIXED) |=> corr_q);
  assert_no_idle_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !uncorr_q) |=> !uncorr_q);
endmodule

// File: rtl/fram_drain_seq.sv
module fram_drain_seq #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic [1:0]        fifo_ecc_i,
  output logic              fifo_rdreq_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              ram_wren_o,
  output logic              ram_rden_o,
  output logic [ADDR_W:0]   word_count_o,
  output logic [1:0]        ecc_status_o,
  output logic              ecc_corr_o,
  output logic              ecc_uncorr_o
);
  logic rdreq, wr, step;

  fram_seq_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .empty_i (fifo_empty_i),
    .rdreq_o (rdreq),
    .wr_o    (wr),
    .step_o  (step)
  );

  fram_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .wr_i    (wr),
    .addr_o  (ram_addr_o),
    .count_o (word_count_o)
  );

  fram_ecc_flags u_ecc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .ecc_i    (fifo_ecc_i),
    .corr_o   (ecc_corr_o),
    .uncorr_o (ecc_uncorr_o)
  );

  assign fifo_rdreq_o = rdreq;
  assign ram_wren_o   = wr;
  assign ram_rden_o   = wr;
  assign ram_data_o   = fifo_data_i;
  assign ecc_status_o = fifo_ecc_i;

  assert_wren_rden_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_wren_o |-> ram_rden_o);
endmodule

// File: tb/sim_fram_drain_seq.sv
module sim_fram_drain_seq;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 64;
  localparam int DEPTH  = 512;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic              fifo_empty;
  logic [DATA_W-1:0] fifo_data_q;
  logic [1:0]        ecc_q;
  logic              ecc_force_en = 1'b0;
  logic [1:0]        ecc_force = 2'b00;
  logic [1:0]        fifo_ecc;
  logic              rdreq, wren, rden, corr, uncorr;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] ram_wdata, ram_q;
  logic [ADDR_W:0]   count;
  logic [1:0]        ecc_out;

  logic [DATA_W-1:0] fmem [DEPTH];
  logic [1:0]        fecc [DEPTH];
  logic [DATA_W-1:0] ram  [256];
  int rd_ptr = 0;
  int wr_ptr = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_ecc   = ecc_force_en ? ecc_force : ecc_q;

  always @(posedge clk) begin
    if (rdreq && rd_ptr != wr_ptr) begin
      fifo_data_q <= fmem[rd_ptr];
      ecc_q       <= fecc[rd_ptr];
      rd_ptr      <= rd_ptr + 1;
    end
  end

  always @(posedge clk) begin
    if (wren) ram[addr] <= ram_wdata;
    if (rden) ram_q <= ram_wdata;
  end

  fram_drain_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_empty_i(fifo_empty),
    .fifo_data_i(fifo_data_q), .fifo_ecc_i(fifo_ecc),
    .fifo_rdreq_o(rdreq), .ram_addr_o(addr), .ram_data_o(ram_wdata),
    .ram_wren_o(wren), .ram_rden_o(rden), .word_count_o(count),
    .ecc_status_o(ecc_out), .ecc_corr_o(corr), .ecc_uncorr_o(uncorr)
  );

  function automatic logic [DATA_W-1:0] word_of(int i);
    return {32'(i) * 32'h9E37_79B1, 32'(i) ^ 32'h5A5A_0F0F};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push(int idx, logic [1:0] e);
    fmem[wr_ptr % DEPTH] = word_of(idx);
    fecc[wr_ptr % DEPTH] = e;
    wr_ptr = wr_ptr + 1;
  endtask

  task automatic t_reset();
    chk("R1 addr", 64'(addr), 64'hFF);
    chk("R1 count", 64'(count), 0);
    chk("R1 flags", 64'({corr, uncorr}), 0);
    chk("R1 enables", 64'({rdreq, wren, rden}), 0);
  endtask

  task automatic t_idle_hold();
    for (int i = 0; i < 5; i++) tick();
    chk("R2 no activity", 64'({rdreq, wren, rden}), 0);
    chk("R2 addr held", 64'(addr), 64'hFF);
  endtask

  task automatic t_one_word(int idx, logic [1:0] e, int exp_cnt);
    push(idx, e);
    tick();
    chk("R3 rdreq", 64'({rdreq, wren}), 64'b10);
    chk("R3 addr step", 64'(addr), 64'(ADDR_W'(idx)));
    tick();
    chk("R4 enables", 64'({rdreq, wren, rden}), 64'b011);
    chk("R4 data", ram_wdata, word_of(idx));
    chk("R8 ecc pass", 64'(ecc_out), 64'(e));
    tick();
    chk("R6 back to idle", 64'({rdreq, wren}), 0);
    chk("R5 count", 64'(count), 64'(exp_cnt));
    chk("R4 ram q", ram_q, word_of(idx));
    chk("R7 ram stored", ram[idx], word_of(idx));
  endtask

  task automatic t_ecc();
    ecc_force_en = 1'b1; ecc_force = 2'b11;
    for (int i = 0; i < 3; i++) tick();
    chk("R9 idle 11 ignored", 64'({corr, uncorr}), 0);
    ecc_force_en = 1'b0;
    t_one_word(2, 2'b01, 3);
    chk("R10 code 01 no flag", 64'({corr, uncorr}), 0);
    t_one_word(3, 2'b10, 4);
    chk("R10 corrected flag", 64'({corr, uncorr}), 64'b10);
    t_one_word(4, 2'b11, 5);
    chk("R9 uncorr flag", 64'({corr, uncorr}), 64'b11);
  endtask

  task automatic t_burst();
    int alt_bad = 0;
    int guard = 0;
    int bad = 0;
    for (int i = 5; i < 256; i++) push(i, 2'b00);
    tick();
    for (int i = 0; i < 20; i++) begin
      if (rdreq == wren) alt_bad++;
      tick();
    end
    chk("R6 alternation", 64'(alt_bad), 0);
    while (count != 9'd256 && guard < 2000) begin tick(); guard++; end
    tick(); tick();
    chk("R5 count 256", 64'(count), 64'd256);
    chk("R5 last addr", 64'(addr), 64'hFF);
    chk("R6 idle after drain", 64'({rdreq, wren}), 0);
    chk("R5 last word q", ram_q, word_of(255));
    for (int i = 0; i < 256; i++) if (ram[i] !== word_of(i)) bad++;
    chk("R5 ram contents", 64'(bad), 0);
    chk("R11 flags kept", 64'({corr, uncorr}), 64'b11);
  endtask

  task automatic t_rearm();
    rst_ni = 1'b0;
    #1;
    chk("R11 cleared by reset", 64'({corr, uncorr}), 0);
    chk("R1 addr after reset", 64'(addr), 64'hFF);
    chk("R1 count after reset", 64'(count), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    ecc_q = 2'b00;
    fifo_data_q = '0;
    ram_q = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_idle_hold();
    t_one_word(0, 2'b00, 1);
    for (int i = 0; i < 4; i++) tick();
    t_one_word(1, 2'b00, 2);
    t_ecc();
    t_burst();
    t_rearm();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule